// File: doc/BRIEF.md
# Four-Channel Serial Converter Emulator

This block stands in for the device side of a small four-channel, 8-bit serial analog-to-digital converter. A host drives an active-low select line, a serial clock that idles high, and a serial data line into the block. The block answers on a single serial data output. Four 8-bit sample words arrive on a parallel bus in place of analog inputs. Every frame lasts sixteen serial clocks. In each frame the host sends a control byte that picks the channel for the next conversion. During the same frame the block returns the sample of the channel that was picked in the frame before.

The host lines are oversampled by a faster system clock through two-stage synchronizers followed by edge detection. All logic therefore runs in one clock domain. The block registers the outgoing bit on every detected falling edge of the serial clock and shifts a serial input bit in on every detected rising edge. A debug output shows the channel address that the most recent complete frame decoded.

Top module: `serial_adc_emu`

## Requirements
- R1: A synchronous active-high reset drives `miso_o` low, sets `last_addr_o` to 0, and makes channel 0 the selected channel.
- R2: While `cs_n_i` is high, `miso_o` stays low and serial clock activity has no effect on `last_addr_o`.
- R3: In a frame, falling serial edge k (k = 0..15, counted from the select falling edge) launches output bit k. Bits 0 to 3 are zero, bits 4 to 11 carry the sample MSB first, and bits 12 to 15 are zero. Each bit holds until the next falling edge.
- R4: Serial input bits are captured on rising edges. The first eight form the control byte, MSB first. The channel address is control bit 4 (address MSB) and bit 3 (address LSB). The other control bits and input bits 8 to 15 are ignored. After a complete frame, `last_addr_o` shows that address.
- R5: The sample returned in a frame belongs to the channel addressed by the previous complete frame, or to channel 0 if there was none since reset. Channel n is read from `sample_bus_i[8n+7:8n]`.
- R6: The returned sample is captured when select falls. Changes on `sample_bus_i` later in the frame do not alter the bits sent.
- R7: Raising select before the sixteenth rising edge aborts the frame. Its address is discarded and `last_addr_o` is unchanged. The next select falling edge restarts the bit count at zero.
- R8: Serial clocks beyond the sixteenth in a frame leave `miso_o` low and do not change the decoded address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Host select, active low, asynchronous |
| sclk_i | input | 1 | Host serial clock, idles high, asynchronous |
| mosi_i | input | 1 | Host serial data into the block |
| sample_bus_i | input | 32 | Four 8-bit sample words, channel n at bits 8n+7:8n |
| miso_o | output | 1 | Serial data to the host, registered |
| last_addr_o | output | 2 | Channel address decoded by the last complete frame |

## Verification
A change on a host pin reaches the logic after two synchronizer stages and one edge-detect comparison. A new `miso_o` bit is therefore due on the third system clock after the serial clock falls, and `last_addr_o` is due on the third system clock after the sixteenth rising edge. The bench holds each serial clock phase for eight system clocks and reads `miso_o` at the end of the low phase, where the host would sample it. It reads `last_addr_o` at least eight system clocks after the frame's last rising edge. With these margins every check lands after the result has settled and before the next stimulus can disturb it.

// File: rtl/serial_adc_emu_pkg.sv
package serial_adc_emu_pkg;

  // Synchronized view of the host lines with detected edges
  typedef struct packed {
    logic cs_low;    // select asserted (synchronized)
    logic cs_fall;   // select just asserted
    logic cs_rise;   // select just released
    logic sck_rise;  // serial clock rising edge
    logic sck_fall;  // serial clock falling edge
    logic mosi;      // synchronized serial data in
  } line_ev_t;

endpackage

// File: rtl/line_sync.sv
module line_sync
  import serial_adc_emu_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cs_n_i,
  input  logic     sclk_i,
  input  logic     mosi_i,
  output line_ev_t ev_o
);

  localparam int NLINES = 3;
  // line order: {mosi, sclk, cs_n}; idle levels used as reset values
  localparam logic [NLINES-1:0] IDLE = 3'b011;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic              cs_d, sck_d;

  assign raw = {mosi_i, sclk_i, cs_n_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{IDLE[i]}};
      else     chain <= {chain[STAGES-2:0], raw[i]};
    end
    assign synced[i] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b1;
    end else begin
      cs_d  <= synced[0];
      sck_d <= synced[1];
    end
  end

  always_comb begin
    ev_o.cs_low   = ~synced[0];
    ev_o.cs_fall  = ~synced[0] & cs_d;
    ev_o.cs_rise  = synced[0] & ~cs_d;
    ev_o.sck_rise = synced[1] & ~sck_d;
    ev_o.sck_fall = ~synced[1] & sck_d;
    ev_o.mosi     = synced[2];
  end

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import serial_adc_emu_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CTRL_BITS  = 8,
  parameter int ADDR_W     = 2,
  parameter int ADDR_LSB   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  line_ev_t          ev_i,
  output logic              active_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] cur_addr_o
);

  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST_CTRL  = CW'(CTRL_BITS - 1);
  localparam logic [CW-1:0] LAST_FRAME = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] CTRL_LIM   = CW'(CTRL_BITS);

  logic [CW-1:0]        cnt_q;
  logic [CTRL_BITS-1:0] ctrl_q;
  logic [CTRL_BITS-1:0] ctrl_nxt;
  logic [ADDR_W-1:0]    pend_q;

  assign ctrl_nxt = {ctrl_q[CTRL_BITS-2:0], ev_i.mosi};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      active_o   <= 1'b0;
      ctrl_q     <= '0;
      pend_q     <= '0;
      cur_addr_o <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!ev_i.cs_low) begin
        active_o <= 1'b0;
        cnt_q    <= '0;
      end else if (ev_i.cs_fall) begin
        active_o <= 1'b1;
        cnt_q    <= '0;
      end else if (active_o && ev_i.sck_rise) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q < CTRL_LIM)
          ctrl_q <= ctrl_nxt;
        if (cnt_q == LAST_CTRL)
          pend_q <= ctrl_nxt[ADDR_LSB +: ADDR_W];
        if (cnt_q == LAST_FRAME) begin
          active_o   <= 1'b0;
          cur_addr_o <= pend_q;
          done_o     <= 1'b1;
        end
      end
    end
  end

  // R7
  abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ev_i.cs_rise |=> (cnt_q == '0 && !active_o));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(FRAME_BITS));

  // R3
  fall_no_count_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_i.sck_fall && ev_i.cs_low) |=> $stable(cnt_q));

  // R4
  addr_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(cnt_q) == LAST_FRAME && $past(ev_i.cs_low)));

endmodule

// File: rtl/tx_shift.sv
module tx_shift #(
  parameter int SAMPLE_W   = 8,
  parameter int NUM_CH     = 4,
  parameter int FRAME_BITS = 16,
  parameter int LEAD       = 4,
  parameter int ADDR_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_i,
  input  logic                       shift_i,
  input  logic                       hold_low_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
  input  logic [ADDR_W-1:0]          sel_i,
  output logic                       miso_o
);

  localparam int TAIL = FRAME_BITS - LEAD - SAMPLE_W;

  logic [SAMPLE_W-1:0]   ch [NUM_CH];
  logic [SAMPLE_W-1:0]   pick;
  logic [FRAME_BITS-1:0] sr_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch[i] = samples_i[i*SAMPLE_W +: SAMPLE_W];
  end

  assign pick = ch[sel_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      miso_o <= 1'b0;
    end else if (hold_low_i) begin
      miso_o <= 1'b0;
    end else if (load_i) begin
      sr_q   <= {{LEAD{1'b0}}, pick, {TAIL{1'b0}}};
      miso_o <= 1'b0;
    end else if (shift_i) begin
      miso_o <= sr_q[FRAME_BITS-1];
      sr_q   <= {sr_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    hold_low_i |=> !miso_o);

  // R3
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_i && !hold_low_i && !load_i) |=> $stable(miso_o));

endmodule

// File: rtl/serial_adc_emu.sv
module serial_adc_emu
  import serial_adc_emu_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int NUM_CH      = 4,
  parameter int FRAME_BITS  = 16,
  parameter int CTRL_BITS   = 8,
  parameter int LEAD        = 4,
  parameter int ADDR_LSB    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n_i,
  input  logic                       sclk_i,
  input  logic                       mosi_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] sample_bus_i,
  output logic                       miso_o,
  output logic [ADDR_W-1:0]          last_addr_o
);

  line_ev_t          ev;
  logic              active;
  logic              done;
  logic [ADDR_W-1:0] cur_addr;

  line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .cs_n_i (cs_n_i),
    .sclk_i (sclk_i),
    .mosi_i (mosi_i),
    .ev_o   (ev)
  );

  frame_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .CTRL_BITS  (CTRL_BITS),
    .ADDR_W     (ADDR_W),
    .ADDR_LSB   (ADDR_LSB)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ev_i       (ev),
    .active_o   (active),
    .done_o     (done),
    .cur_addr_o (cur_addr)
  );

  tx_shift #(
    .SAMPLE_W   (SAMPLE_W),
    .NUM_CH     (NUM_CH),
    .FRAME_BITS (FRAME_BITS),
    .LEAD       (LEAD),
    .ADDR_W     (ADDR_W)
  ) u_tx (
    .clk        (clk),
    .rst        (rst),
    .load_i     (ev.cs_fall),
    .shift_i    (active && ev.sck_fall),
    .hold_low_i (!ev.cs_low),
    .samples_i  (sample_bus_i),
    .sel_i      (cur_addr),
    .miso_o     (miso_o)
  );

  assign last_addr_o = cur_addr;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!miso_o && last_addr_o == '0));

  // R5
  addr_change_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(last_addr_o) |-> done);

endmodule

// File: tb/sim_serial_adc_emu.sv
module sim_serial_adc_emu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        mosi = 1'b0;
  logic [31:0] samples = '0;
  logic        miso;
  logic [1:0]  last;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  serial_adc_emu u0 (
    .clk          (clk),
    .rst          (rst),
    .cs_n_i       (cs_n),
    .sclk_i       (sclk),
    .mosi_i       (mosi),
    .sample_bus_i (samples),
    .miso_o       (miso),
    .last_addr_o  (last)
  );

  // {control byte, ch3, ch2, ch1, ch0}
  localparam logic [39:0] VEC [8] = '{
    {8'h08, 8'h44, 8'h33, 8'h22, 8'h11},
    {8'h10, 8'hA5, 8'h5A, 8'hC3, 8'h3C},
    {8'h18, 8'h80, 8'h01, 8'hFF, 8'h7E},
    {8'h00, 8'h96, 8'h69, 8'h0F, 8'hF0},
    {8'h9A, 8'h12, 8'h34, 8'h56, 8'h78},
    {8'h6F, 8'hDE, 8'hAD, 8'hBE, 8'hEF},
    {8'hF7, 8'h01, 8'h02, 8'h04, 8'h08},
    {8'hE7, 8'hFE, 8'hFD, 8'hFB, 8'hF7}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_bits(input logic [7:0] s, input int n);
    logic [23:0] e;
    logic [23:0] m;
    e = {4'b0, s, 12'b0};
    m = ~(24'hFFFFFF >> n);
    return e & m;
  endfunction

  task automatic run_frame(input logic [7:0] ctrl, input int nclk,
                           input int chg_at, input logic [31:0] chg_val,
                           output logic [23:0] got);
    got = '0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < nclk; k++) begin
      if (k == chg_at) samples = chg_val;
      sclk = 1'b0;
      mosi = (k < 8) ? ctrl[7-k] : k[0];
      repeat (8) @(negedge clk);
      if (k < 24) got[23-k] = miso;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] got;
    logic [1:0]  prev;
    logic [7:0]  s;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(miso == 1'b0, "R1 miso", 32'(miso), 0);
    chk(last == 2'd0, "R1 addr", 32'(last), 0);

    prev = 2'd0;
    for (int i = 0; i < 8; i++) begin
      samples = VEC[i][31:0];
      s = samples[prev*8 +: 8];
      run_frame(VEC[i][39:32], 16, -1, '0, got);
      // R3 R5 pattern and previous-frame channel
      chk(got == exp_bits(s, 16), "R3 R5 data", 32'(got), 32'(exp_bits(s, 16)));
      prev = VEC[i][36:35];
      // R4 address bits 4:3
      chk(last == prev, "R4 addr", 32'(last), 32'(prev));
    end

    // R2: clocks with select high
    samples = 32'h5555_AAAA;
    for (int k = 0; k < 4; k++) begin
      sclk = 1'b0; mosi = 1'b1;
      repeat (8) @(negedge clk);
      chk(miso == 1'b0, "R2 miso idle", 32'(miso), 0);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
    end
    chk(last == prev, "R2 addr idle", 32'(last), 32'(prev));

    // R7 abort after 10 clocks
    samples = 32'h9C8B7A69;
    s = samples[prev*8 +: 8];
    run_frame(8'h18, 10, -1, '0, got);
    chk(got == exp_bits(s, 10), "R7 partial data", 32'(got), 32'(exp_bits(s, 10)));
    chk(last == prev, "R7 addr kept", 32'(last), 32'(prev));
    run_frame(8'h08, 16, -1, '0, got);
    chk(got == exp_bits(s, 16), "R7 restart data", 32'(got), 32'(exp_bits(s, 16)));
    prev = 2'd1;
    chk(last == prev, "R7 addr after restart", 32'(last), 32'(prev));

    // R6 sample change mid-frame
    samples = 32'h1122_3344;
    s = samples[prev*8 +: 8];
    run_frame(8'h10, 16, 5, 32'hEEDD_CCBB, got);
    chk(got == exp_bits(s, 16), "R6 latched data", 32'(got), 32'(exp_bits(s, 16)));
    prev = 2'd2;
    chk(last == prev, "R6 addr", 32'(last), 32'(prev));

    // R8 extra clocks
    samples = 32'hF00F_C33C;
    s = samples[prev*8 +: 8];
    run_frame(8'h08, 20, -1, '0, got);
    chk(got == exp_bits(s, 20), "R8 tail low", 32'(got), 32'(exp_bits(s, 20)));
    prev = 2'd1;
    chk(last == prev, "R8 addr", 32'(last), 32'(prev));

    // R1 mid-run reset, then R5 default channel 0
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(last == 2'd0, "R1 addr after reset", 32'(last), 0);
    samples = 32'h0403_0201;
    run_frame(8'h18, 16, -1, '0, got);
    chk(got == exp_bits(8'h01, 16), "R5 channel 0 default", 32'(got),
        32'(exp_bits(8'h01, 16)));
    chk(last == 2'd3, "R4 addr after reset", 32'(last), 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule